// File: doc/BRIEF.md
# Predicated 16-bit Register-Machine Core

A small multi-cycle processor core with 16-bit words. It fetches instructions from an external read-only program memory through a synchronous read port: the address and request go out in one cycle, and the word comes back in the next. Each instruction carries a 4-bit operation code, a 3-bit condition code and two 4-bit register indices. The core evaluates the condition against three flag bits before it acts. If the condition fails, the instruction does nothing.

The register file has seven entries: four general registers, a flag register, the program counter and a stack pointer. Every entry can be used as an operand, so a jump is an ordinary move, add or load into the program counter, and a conditional jump is a move with a condition. A character-output instruction places a register value on a data port with a one-cycle valid strobe. Malformed instructions stop the core and raise a sticky illegal-operation status. A dedicated stop operation halts the core cleanly. Only a synchronous reset restarts it.

Top module: `pred_core`

## Requirements
- R1: While reset is high and in the first cycle after it is released, halted, illegal and out_valid are low, and the first fetch requests address 0 with all registers cleared.
- R2: The instruction word is split as follows: operation code in bits 15:12, condition code in bits 11:9, target register index in bits 7:4 and source register index in bits 3:0. Each instruction is fetched by raising imem_req with imem_addr equal to the program counter. A single-word instruction takes three cycles (fetch, latch, execute), and the program counter passes the instruction word before the condition is evaluated.
- R3: Condition codes: 0 never holds; 1 holds when flag bit 2 is clear; 2 holds when flag bit 2 is set; 3 holds when flag bit 0 is set; 4 holds when flag bit 1 is set; 7 always holds. An instruction whose condition fails changes no register except the program counter.
- R4: Operation 0 writes the word that follows it into the target register and leaves the program counter two words past the instruction. It takes five cycles and requests the second word at the incremented counter. When its condition fails, it takes three cycles and still skips the second word.
- R5: Operation 1 requests program memory at the address held in the source register, one cycle after execute, and writes the returned word to the target register. It takes five cycles.
- R6: Operation 2 raises out_valid for exactly one cycle, carrying the source register value on out_data. The pulse is seen in the cycle after execute. The target register must hold 0x4000; if it does not, the core raises illegal and halts with no pulse.
- R7: Operation 3 copies the source into the target. Operation 4 adds the source to the target modulo 2^16. Operation 6 stores target AND source in the target. Operation 7 stores the bitwise complement of the target in the target.
- R8: Operation 5 compares the source and target registers as unsigned values and writes only the flag register. The flag register becomes zero except for one bit: bit 2 if the two are equal, bit 0 if the source is greater, or bit 1 if the source is smaller.
- R9: An instruction that writes register 5 replaces the incremented program counter, and the next fetch is taken from the written value.
- R10: When the condition holds, a register index above 6 in a field the operation uses raises illegal and halts. When the condition fails, the index is not examined.
- R11: Condition codes 5 and 6, and operation codes 8 to 14, raise illegal and halt. Illegal stays high until reset.
- R12: Operation 15 halts the core whatever its condition. Once halted, the core issues no further memory requests and no output pulses, and halted stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Program memory read request |
| imem_addr | output | ADDR_W | Program memory read address |
| imem_rdata | input | DATA_W | Program memory word, valid the cycle after the request |
| out_valid | output | 1 | One-cycle strobe for out_data |
| out_data | output | DATA_W | Value sent by the output operation |
| halted | output | 1 | Core has stopped, sticky until reset |
| illegal | output | 1 | Stop was caused by a malformed instruction |

## Verification
The bench goes after the following corner cases, each with the failure it would show:
- **Skipped immediate.** A core that forgets to skip the immediate word after a failed condition executes that word as an instruction, so the fetch addresses drift.
- **Program counter as an operand.** A core that sees the pre-increment value, or lets the increment override a write to register 5, fetches from the wrong place after a jump.
- **Flag encoding.** An unsigned comparison across 0xFFFF and 0 must set the greater-than bit. A signed comparison, or a flag word that keeps stale bits, picks the wrong conditional path.
- **Illegal forms.** The bench plants a never-executed instruction with bad register indices. A core that checks indices before the condition traps on it. A core that misses condition codes 5 and 6, undefined operations, or an output with a wrong tag keeps running instead of halting.

// File: rtl/pcore_pkg.sv
package pcore_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int OPC_W  = 4;
  localparam int PRED_W = 3;
  localparam int RIDX_W = 4;
  localparam int NUM_REGS = 7;
  localparam int FLAG_BITS = 3;

  // register slots with architectural meaning
  localparam int SLOT_FLAG = 4;
  localparam int SLOT_PC   = 5;
  localparam logic [RIDX_W-1:0] RIX_FLAG = RIDX_W'(SLOT_FLAG);

  // flag bit positions
  localparam int FLG_GT = 0;
  localparam int FLG_LT = 1;
  localparam int FLG_EQ = 2;

  // operation codes
  localparam logic [OPC_W-1:0] OPC_LDI  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LDM  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_OUT  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_MOV  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_CMP  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_NOT  = 4'd7;
  localparam logic [OPC_W-1:0] OPC_STOP = 4'd15;

  // condition codes
  localparam logic [PRED_W-1:0] CND_NEVER  = 3'd0;
  localparam logic [PRED_W-1:0] CND_NZ     = 3'd1;
  localparam logic [PRED_W-1:0] CND_Z      = 3'd2;
  localparam logic [PRED_W-1:0] CND_GT     = 3'd3;
  localparam logic [PRED_W-1:0] CND_LT     = 3'd4;
  localparam logic [PRED_W-1:0] CND_BAD5   = 3'd5;
  localparam logic [PRED_W-1:0] CND_BAD6   = 3'd6;
  localparam logic [PRED_W-1:0] CND_ALWAYS = 3'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_EXEC, ST_IMM_REQ, ST_IMM_WR, ST_LD_REQ, ST_LD_WR, ST_STOP
  } cstate_t;

  // latched instruction fields (the unused word bit is not kept)
  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [PRED_W-1:0] cnd;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rs;
  } ifields_t;
endpackage

// File: rtl/pcore_alu.sv
module pcore_alu
  import pcore_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] tgt,
  output logic [DATA_W-1:0] res
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    res = src;
    case (opc)
      OPC_MOV: res = src;
      OPC_ADD: res = src + tgt;
      OPC_AND: res = src & tgt;
      OPC_NOT: res = ~tgt;
      OPC_CMP: begin
        res = '0;
        res[FLG_EQ] = (src == tgt);
        res[FLG_GT] = (src > tgt);
        res[FLG_LT] = (src < tgt);
      end
      default: res = src;
    endcase
  end
endmodule

// File: rtl/pcore_decode.sv
module pcore_decode
  import pcore_pkg::*;
(
  input  ifields_t             f,
  input  logic [FLAG_BITS-1:0] flg,
  output logic                 cnd_pass,
  output logic                 cnd_bad,
  output logic                 opc_bad,
  output logic                 opc_stop,
  output logic                 idx_bad
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [RIDX_W-1:0] LAST_IX = RIDX_W'(NUM_REGS - 1);

  logic rs_used;

  always_comb begin
    cnd_bad  = 1'b0;
    cnd_pass = 1'b0;
    case (f.cnd)
      CND_NEVER:  cnd_pass = 1'b0;
      CND_NZ:     cnd_pass = !flg[FLG_EQ];
      CND_Z:      cnd_pass = flg[FLG_EQ];
      CND_GT:     cnd_pass = flg[FLG_GT];
      CND_LT:     cnd_pass = flg[FLG_LT];
      CND_ALWAYS: cnd_pass = 1'b1;
      default:    cnd_bad  = 1'b1;
    endcase
  end

  always_comb begin
    opc_stop = (f.opc == OPC_STOP);
    opc_bad  = f.opc[OPC_W-1] && !opc_stop;
    rs_used  = !(f.opc == OPC_LDI || f.opc == OPC_NOT);
    idx_bad  = (f.rt > LAST_IX) || (rs_used && (f.rs > LAST_IX));
  end
endmodule

// File: rtl/pcore_regfile.sv
module pcore_regfile
  import pcore_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = NUM_REGS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RIDX_W-1:0]    rd_a_idx,
  output logic [DATA_W-1:0]    rd_a,
  input  logic [RIDX_W-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]    rd_b,
  input  logic                 wr_en,
  input  logic [RIDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 pc_inc,
  output logic [DATA_W-1:0]    pc_q,
  output logic [FLAG_BITS-1:0] flag_q
);
  timeunit 1ns; timeprecision 1ps;

  localparam int SEL_W = $clog2(NREGS);
  localparam logic [RIDX_W-1:0] NREGS_IX = RIDX_W'(NREGS);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] q [NREGS];

  // the explicit write comes last so it overrides the counter increment
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) q[i] <= '0;
    end else begin
      if (pc_inc) q[SLOT_PC] <= q[SLOT_PC] + ONE;
      if (wr_en && (wr_idx < NREGS_IX)) q[wr_idx[SEL_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_a   = (rd_a_idx < NREGS_IX) ? q[rd_a_idx[SEL_W-1:0]] : '0;
    rd_b   = (rd_b_idx < NREGS_IX) ? q[rd_b_idx[SEL_W-1:0]] : '0;
    pc_q   = q[SLOT_PC];
    flag_q = q[SLOT_FLAG][FLAG_BITS-1:0];
  end
endmodule

// File: rtl/pred_core.sv
module pred_core
  import pcore_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [DATA_W-1:0] OUT_TAG = 16'h4000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_req,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [DATA_W-1:0] imem_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              halted,
  output logic              illegal
);
  timeunit 1ns; timeprecision 1ps;

  cstate_t state;
  ifields_t ir;

  logic [DATA_W-1:0] tgt_val, src_val, pc_val, alu_res;
  logic [FLAG_BITS-1:0] flg;
  logic cnd_pass, cnd_bad, opc_bad, opc_stop, idx_bad;
  logic in_exec, tag_bad, trap, run;
  logic wr_en, pc_inc;
  logic [RIDX_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;

  pcore_decode u_dec (
    .f        (ir),
    .flg      (flg),
    .cnd_pass (cnd_pass),
    .cnd_bad  (cnd_bad),
    .opc_bad  (opc_bad),
    .opc_stop (opc_stop),
    .idx_bad  (idx_bad)
  );

  pcore_regfile #(.DATA_W(DATA_W), .NREGS(NUM_REGS)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (ir.rt),
    .rd_a     (tgt_val),
    .rd_b_idx (ir.rs),
    .rd_b     (src_val),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .pc_inc   (pc_inc),
    .pc_q     (pc_val),
    .flag_q   (flg)
  );

  pcore_alu #(.DATA_W(DATA_W)) u_alu (
    .opc (ir.opc),
    .src (src_val),
    .tgt (tgt_val),
    .res (alu_res)
  );

  // execute-stage qualification
  always_comb begin
    in_exec = (state == ST_EXEC);
    tag_bad = (ir.opc == OPC_OUT) && (tgt_val != OUT_TAG);
    trap    = in_exec && !opc_stop &&
              (opc_bad || cnd_bad || (cnd_pass && (idx_bad || tag_bad)));
    run     = in_exec && !opc_stop && !opc_bad && !cnd_bad && cnd_pass &&
              !idx_bad && !tag_bad;
  end

  // register-file write port
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = ir.rt;
    wr_data = alu_res;
    if (run) begin
      case (ir.opc)
        OPC_MOV, OPC_ADD, OPC_AND, OPC_NOT: wr_en = 1'b1;
        OPC_CMP: begin
          wr_en  = 1'b1;
          wr_idx = RIX_FLAG;
        end
        default: wr_en = 1'b0;
      endcase
    end
    if (state == ST_IMM_WR || state == ST_LD_WR) begin
      wr_en   = 1'b1;
      wr_data = imem_rdata;
    end
    pc_inc = (state == ST_LATCH) || (state == ST_IMM_WR) ||
             (in_exec && ir.opc == OPC_LDI && !cnd_bad && !cnd_pass);
  end

  // memory port
  always_comb begin
    imem_req  = (state == ST_FETCH) || (state == ST_IMM_REQ) || (state == ST_LD_REQ);
    imem_addr = (state == ST_LD_REQ) ? src_val[ADDR_W-1:0] : pc_val[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      ir        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_FETCH: state <= ST_LATCH;
        ST_LATCH: begin
          ir.opc <= imem_rdata[15:12];
          ir.cnd <= imem_rdata[11:9];
          ir.rt  <= imem_rdata[7:4];
          ir.rs  <= imem_rdata[3:0];
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          if (opc_stop) begin
            halted <= 1'b1;
            state  <= ST_STOP;
          end else if (trap) begin
            halted  <= 1'b1;
            illegal <= 1'b1;
            state   <= ST_STOP;
          end else if (run && ir.opc == OPC_LDI) begin
            state <= ST_IMM_REQ;
          end else if (run && ir.opc == OPC_LDM) begin
            state <= ST_LD_REQ;
          end else begin
            if (run && ir.opc == OPC_OUT) begin
              out_valid <= 1'b1;
              out_data  <= src_val;
            end
            state <= ST_FETCH;
          end
        end
        ST_IMM_REQ: state <= ST_IMM_WR;
        ST_IMM_WR:  state <= ST_FETCH;
        ST_LD_REQ:  state <= ST_LD_WR;
        ST_LD_WR:   state <= ST_FETCH;
        default:    state <= ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/pred_core_chk.sv
module pred_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              imem_req,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              out_valid,
  input logic              halted,
  input logic              illegal
);
  timeunit 1ns; timeprecision 1ps;

  // R1: first cycle out of reset fetches address 0
  a_r1_first_fetch_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (imem_req && imem_addr == '0 && !halted && !illegal));

  // R6: output strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6, R12: no output once stopped
  a_r6_no_out_when_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);

  // R12: halted is sticky and silences memory
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r12_no_req_when_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !imem_req);

  // R11: illegal implies stop and is sticky
  a_r11_illegal_halts: assert property (@(posedge clk) disable iff (rst)
    illegal |-> halted);
  a_r11_illegal_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);
endmodule

bind pred_core pred_core_chk u_chk (.*);

// File: tb/tb_pred_core.sv
module tb_pred_core;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_req;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata;
  logic out_valid;
  logic [15:0] out_data;
  logic halted, illegal;

  logic [15:0] rom [256];
  int checks = 0;
  int errors = 0;
  int wp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (imem_req) imem_rdata <= rom[imem_addr[7:0]];

  pred_core dut (
    .clk(clk), .rst(rst), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .illegal(illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int cn, input int rt, input int rs);
    return {4'(op), 3'(cn), 1'b0, 4'(rt), 4'(rs)};
  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    wp = 0;
  endtask

  task automatic put(input logic [15:0] w);
    rom[wp] = w;
    wp++;
  endtask

  // behavioural reference: executes one instruction per loop and predicts every cycle
  task automatic run_prog(input string tag);
    logic [15:0] r [16];
    logic [15:0] iv, d;
    int op, cn, rt, rs, steps;
    bit pend, mh, mi, ok, bad;
    logic [15:0] pdata;
    for (int i = 0; i < 16; i++) r[i] = 16'h0;
    pend = 0; mh = 0; mi = 0; steps = 0; pdata = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", {tag, " reset halted"}, int'(halted), 0);
    chk("R1", {tag, " reset illegal"}, int'(illegal), 0);
    chk("R1", {tag, " reset out_valid"}, int'(out_valid), 0);
    @(posedge clk); #1 rst = 1'b0;
    while (!mh && steps < 400) begin
      iv = rom[r[5][7:0]];
      op = int'(iv[15:12]); cn = int'(iv[11:9]); rt = int'(iv[7:4]); rs = int'(iv[3:0]);
      @(negedge clk); // fetch
      chk("R2", {tag, " fetch req"}, int'(imem_req), 1);
      chk("R2", {tag, " fetch addr"}, int'(imem_addr), int'(r[5]));
      chk("R6", {tag, " out_valid"}, int'(out_valid), int'(pend));
      if (pend) chk("R6", {tag, " out_data"}, int'(out_data), int'(pdata));
      chk("R12", {tag, " halted early"}, int'(halted), 0);
      chk("R11", {tag, " illegal early"}, int'(illegal), 0);
      pend = 0;
      r[5] = r[5] + 16'd1;
      @(negedge clk); // latch
      chk("R2", {tag, " latch req"}, int'(imem_req), 0);
      chk("R6", {tag, " latch out_valid"}, int'(out_valid), 0);
      @(negedge clk); // execute
      chk("R2", {tag, " exec req"}, int'(imem_req), 0);
      case (cn)
        0: ok = 0;
        1: ok = !r[4][2];
        2: ok = r[4][2];
        3: ok = r[4][0];
        4: ok = r[4][1];
        default: ok = 1;
      endcase
      if (op == 15) mh = 1;
      else if (op >= 8 || cn == 5 || cn == 6) begin mh = 1; mi = 1; end
      else if (!ok) begin
        if (op == 0) r[5] = r[5] + 16'd1;
      end else begin
        bad = (rt > 6) || ((op != 0 && op != 7) && rs > 6);
        if (!bad && op == 2 && r[rt] != 16'h4000) bad = 1;
        if (bad) begin mh = 1; mi = 1; end
        else case (op)
          0: begin
            @(negedge clk);
            chk("R4", {tag, " imm req"}, int'(imem_req), 1);
            chk("R4", {tag, " imm addr"}, int'(imem_addr), int'(r[5]));
            @(negedge clk);
            d = rom[r[5][7:0]];
            r[5] = r[5] + 16'd1;
            r[rt] = d;
          end
          1: begin
            @(negedge clk);
            chk("R5", {tag, " load req"}, int'(imem_req), 1);
            chk("R5", {tag, " load addr"}, int'(imem_addr), int'(r[rs]));
            @(negedge clk);
            r[rt] = rom[r[rs][7:0]];
          end
          2: begin pend = 1; pdata = r[rs]; end
          3: r[rt] = r[rs];
          4: r[rt] = r[rt] + r[rs];
          5: r[4] = (r[rs] == r[rt]) ? 16'd4 : (r[rs] > r[rt]) ? 16'd1 : 16'd2;
          6: r[rt] = r[rt] & r[rs];
          default: r[rt] = ~r[rt];
        endcase
      end
      steps++;
    end
    repeat (4) begin
      @(negedge clk);
      chk("R12", {tag, " halted"}, int'(halted), 1);
      chk("R11", {tag, " illegal flag"}, int'(illegal), int'(mi));
      chk("R12", {tag, " no req after stop"}, int'(imem_req), 0);
      chk("R12", {tag, " no out after stop"}, int'(out_valid), 0);
    end
  endtask

  initial begin
    // R4 R6 R7: immediates, arithmetic, output, skipped immediate
    clear_rom();
    put(enc(0,7,3,0)); put(16'h4000);
    put(enc(0,7,0,0)); put(16'hFFFE);
    put(enc(0,7,1,0)); put(16'h0005);
    put(enc(4,7,0,1));            // R7 add wraps to 3
    put(enc(2,7,3,0));
    put(enc(3,7,2,1));
    put(enc(6,7,2,0));
    put(enc(2,7,3,2));
    put(enc(7,7,1,0));
    put(enc(2,7,3,1));
    put(enc(0,0,0,0)); put(16'h1234);   // R4 condition never: word skipped
    put(enc(2,7,3,0));
    put(enc(2,7,3,6));
    put(enc(15,0,0,0));
    run_prog("R4 R6 R7");

    // R3 R8 R9: loop by branch, unsigned compare, conditional moves
    clear_rom();
    put(enc(0,7,3,0)); put(16'h4000);
    put(enc(0,7,0,0)); put(16'd3);
    put(enc(0,7,1,0)); put(16'hFFFF);
    put(enc(0,7,2,0)); put(16'd0);
    put(enc(2,7,3,0));            // address 8
    put(enc(4,7,0,1));
    put(enc(5,7,2,0));
    put(enc(0,1,5,0)); put(16'd8);  // R9 branch while not equal
    put(enc(2,7,3,4));
    put(enc(5,7,0,1));            // R8 0xFFFF vs 0 unsigned greater
    put(enc(3,3,0,1));
    put(enc(3,4,0,3));
    put(enc(2,7,3,0));
    put(enc(5,7,1,2));            // R8 source smaller
    put(enc(3,4,0,2));
    put(enc(3,2,0,3));            // R3 skipped
    put(enc(2,7,3,0));
    put(enc(2,7,3,4));
    put(enc(0,7,1,0)); put(16'd27);
    put(enc(3,7,5,1));            // R9 jump by move
    put(enc(2,7,3,1));
    put(enc(2,7,3,5));
    put(enc(15,7,0,0));
    run_prog("R3 R8 R9");

    // R5: loads from program memory, including through the counter
    clear_rom();
    put(enc(0,7,3,0)); put(16'h4000);
    put(enc(0,7,0,0)); put(16'd40);
    put(enc(1,7,1,0));
    put(enc(2,7,3,1));
    put(enc(1,7,2,5));
    put(enc(2,7,3,2));
    put(enc(1,0,1,0));
    put(enc(2,7,3,1));
    put(enc(15,7,0,0));
    rom[40] = 16'hBEEF;
    run_prog("R5");

    // R11: undefined operation
    clear_rom();
    put(enc(3,7,0,1));
    put(enc(9,7,0,0));
    run_prog("R11 opcode");

    // R11: reserved condition code
    clear_rom();
    put(enc(3,5,0,1));
    run_prog("R11 condition");

    // R10: bad index ignored under a failed condition, trapped otherwise
    clear_rom();
    put(enc(3,0,9,9));
    put(enc(0,0,8,0)); put(16'h0001);
    put(enc(3,7,0,7));
    run_prog("R10 source");

    clear_rom();
    put(enc(0,7,8,0)); put(16'h0001);
    run_prog("R10 target");

    // R6: output with a wrong tag in the target register
    clear_rom();
    put(enc(2,7,0,1));
    run_prog("R6 tag");

    // R12: stop under a never condition still stops
    clear_rom();
    put(enc(15,0,0,0));
    run_prog("R12 stop");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule